// File: doc/BRIEF.md
# Effective Address Generator

This block forms the operand address for the memory-reference instructions of a 16-bit processor. A request carries the opcode, the 9-bit offset field of the instruction, the program counter as it stands after the fetch increment, and the value already read from the selected base register. The block adds the right sign-extended offset to the right operand, or takes the trap vector. It returns the address together with an access kind and a flag that marks an indirect access. The register-selector bits of the instruction play no part in this block, so they are not ports. Register reads, register writes and the memory itself sit outside the block.

For the two indirect opcodes the block does a pointer read of its own. It first forms the PC-relative address and places it on a read port. It then waits for the memory to signal ready, keeps the word that comes back, and reports that word as the final address. For the address-load opcode the computed value is returned as register write data, and no memory access is requested.

The request and result sides are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so one request is in flight at a time. Once `out_valid` is high, it stays high and every result field holds its value until the edge where `out_ready` is also high. The pointer read uses the same rule: `ind_rd_valid` and `ind_rd_addr` hold until `ind_rd_ready` is sampled high, and `ind_rd_data` must be valid in that same cycle.

Top module: `effective_addr_gen`

## Requirements
- R1: For opcodes 0010 (load) and 0011 (store), `out_addr` equals `req_pc` plus `req_field[8:0]` sign-extended to 16 bits, modulo 2^16.
- R2: For opcodes 0110 (load) and 0111 (store), `out_addr` equals `req_base` plus `req_field[5:0]` sign-extended to 16 bits, modulo 2^16.
- R3: For opcodes 1010 (load) and 1011 (store), a pointer read is issued at `req_pc` + sign-extended `req_field[8:0]` (mod 2^16). The word returned becomes `out_addr`, and `out_indirect` is 1. For every other opcode `out_indirect` is 0.
- R4: For opcode 1110, `out_addr` is the PC-relative sum of R1 and `out_kind` is 3 (register write). No pointer read is issued.
- R5: For opcode 1111, `out_addr` is `req_field[7:0]` zero-extended and `out_kind` is 4 (trap).
- R6: `out_kind` is 1 (load) for opcodes 0010, 0110 and 1010, and 2 (store) for 0011, 0111 and 1011. Any opcode not named in R1 to R5 gives kind 0, `out_addr` 0 and no pointer read.
- R7: `req_ready` is high only when idle, and a request presented while busy is ignored. For a direct opcode, `out_valid` is high in the cycle after acceptance. For an indirect opcode, `ind_rd_valid` is high in the cycle after acceptance.
- R8: `ind_rd_valid` and `ind_rd_addr` hold until `ind_rd_ready` is seen, and `out_valid` rises in the cycle after it.
- R9: While `out_valid` is high and `out_ready` is low, all result fields hold. `done` is high for exactly the one cycle after the result is taken, and the block is idle again in that cycle.
- R10: During reset, `req_ready` is 1 and `out_valid`, `ind_rd_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_opcode | input | 4 | Instruction opcode field |
| req_field | input | 9 | Low nine instruction bits (offsets, trap vector) |
| req_pc | input | 16 | Program counter after fetch increment |
| req_base | input | 16 | Base register contents |
| ind_rd_valid | output | 1 | Pointer read request |
| ind_rd_addr | output | 16 | Pointer read address |
| ind_rd_ready | input | 1 | Memory has answered the pointer read |
| ind_rd_data | input | 16 | Word read, valid with ind_rd_ready |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 16 | Final address or register write value |
| out_kind | output | 3 | 0 none, 1 load, 2 store, 3 register write, 4 trap |
| out_indirect | output | 1 | Result came through a pointer read |
| done | output | 1 | One-cycle pulse after the result is taken |

## Verification
A wrong adder operand or the wrong extension of an offset field shows on `out_addr` in the first cycle that `out_valid` is high, one cycle after acceptance. For indirect opcodes the same error already shows on `ind_rd_addr`, in the cycle after acceptance. A sequencer stuck in the wrong state, or one that leaves a state too early, shows as a missing or early `out_valid`, as `ind_rd_valid` dropping before `ind_rd_ready`, or as `req_ready` going high while a result is still pending. Each of these is visible within one cycle of the handshake concerned. A kind-decode error shows on `out_kind` or `out_indirect` together with the result.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam logic [3:0] OPC_LD_PC   = 4'b0010;
  localparam logic [3:0] OPC_ST_PC   = 4'b0011;
  localparam logic [3:0] OPC_LD_BASE = 4'b0110;
  localparam logic [3:0] OPC_ST_BASE = 4'b0111;
  localparam logic [3:0] OPC_LD_IND  = 4'b1010;
  localparam logic [3:0] OPC_ST_IND  = 4'b1011;
  localparam logic [3:0] OPC_ADDR    = 4'b1110;
  localparam logic [3:0] OPC_TRAP    = 4'b1111;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_LOAD  = 3'd1,
    K_STORE = 3'd2,
    K_REGW  = 3'd3,
    K_TRAP  = 3'd4
  } acc_kind_e;

  typedef enum logic [1:0] {
    SRC_PC   = 2'd0,
    SRC_BASE = 2'd1,
    SRC_VEC  = 2'd2
  } addr_src_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_RESP  = 2'd2
  } seq_state_e;

  typedef struct packed {
    acc_kind_e kind;
    addr_src_e src;
    logic      indirect;
  } dec_t;
endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
(
  input  logic [3:0] opcode,
  output dec_t       dec
);
  always_comb begin
    dec = '{kind: K_NONE, src: SRC_PC, indirect: 1'b0};
    unique case (opcode)
      OPC_LD_PC:   dec = '{kind: K_LOAD,  src: SRC_PC,   indirect: 1'b0};
      OPC_ST_PC:   dec = '{kind: K_STORE, src: SRC_PC,   indirect: 1'b0};
      OPC_LD_BASE: dec = '{kind: K_LOAD,  src: SRC_BASE, indirect: 1'b0};
      OPC_ST_BASE: dec = '{kind: K_STORE, src: SRC_BASE, indirect: 1'b0};
      OPC_LD_IND:  dec = '{kind: K_LOAD,  src: SRC_PC,   indirect: 1'b1};
      OPC_ST_IND:  dec = '{kind: K_STORE, src: SRC_PC,   indirect: 1'b1};
      OPC_ADDR:    dec = '{kind: K_REGW,  src: SRC_PC,   indirect: 1'b0};
      OPC_TRAP:    dec = '{kind: K_TRAP,  src: SRC_VEC,  indirect: 1'b0};
      default:     dec = '{kind: K_NONE,  src: SRC_PC,   indirect: 1'b0};
    endcase
  end
endmodule

// File: rtl/eag_sext.sv
module eag_sext #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;
  generate
    if (PAD_W > 0) begin : g_pad
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
    end else begin : g_same
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
  import eag_pkg::*;
#(
  parameter int W          = 16,
  parameter int FIELD_W    = 9,
  parameter int BASE_OFF_W = 6,
  parameter int VEC_W      = 8
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [W-1:0]       pc,
  input  logic [W-1:0]       base,
  input  addr_src_e          src,
  output logic [W-1:0]       addr
);
  localparam int VEC_PAD = W - VEC_W;

  logic [W-1:0] pc_off, base_off, vec_addr;

  eag_sext #(.IN_W(FIELD_W), .OUT_W(W)) u_pc_sext (
    .din (field),
    .dout(pc_off)
  );

  eag_sext #(.IN_W(BASE_OFF_W), .OUT_W(W)) u_base_sext (
    .din (field[BASE_OFF_W-1:0]),
    .dout(base_off)
  );

  assign vec_addr = {{VEC_PAD{1'b0}}, field[VEC_W-1:0]};

  // Single adder shared by both relative modes; wraps modulo 2^W.
  logic [W-1:0] add_a, add_b;
  always_comb begin
    add_a = (src == SRC_BASE) ? base : pc;
    add_b = (src == SRC_BASE) ? base_off : pc_off;
    addr  = (src == SRC_VEC) ? vec_addr : add_a + add_b;
  end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
  import eag_pkg::*;
#(
  parameter int W     = 16,
  parameter int VEC_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  dec_t         dec,
  input  logic [W-1:0] calc_addr,
  output logic         ind_rd_valid,
  output logic [W-1:0] ind_rd_addr,
  input  logic         ind_rd_ready,
  input  logic [W-1:0] ind_rd_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_addr,
  output acc_kind_e    out_kind,
  output logic         out_indirect,
  output logic         done
);
  seq_state_e   state;
  logic [W-1:0] addr_q;
  acc_kind_e    kind_q;
  logic         ind_q;
  logic         done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      kind_q <= K_NONE;
      ind_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          kind_q <= dec.kind;
          ind_q  <= dec.indirect;
          addr_q <= (dec.kind == K_NONE) ? '0 : calc_addr;
          state  <= dec.indirect ? S_FETCH : S_RESP;
        end
        S_FETCH: if (ind_rd_ready) begin
          addr_q <= ind_rd_data;
          state  <= S_RESP;
        end
        S_RESP: if (out_ready) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == S_IDLE);
  assign ind_rd_valid = (state == S_FETCH);
  assign ind_rd_addr  = addr_q;
  assign out_valid    = (state == S_RESP);
  assign out_addr     = addr_q;
  assign out_kind     = kind_q;
  assign out_indirect = ind_q;
  assign done         = done_q;

  p_mutex_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, ind_rd_valid, out_valid}));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid || ind_rd_valid);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ind_rd_valid && !ind_rd_ready |=> ind_rd_valid && $stable(ind_rd_addr));

  p_rd_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ind_rd_valid && ind_rd_ready |=> out_valid && out_indirect && out_addr == $past(ind_rd_data));

  p_rd_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ind_rd_valid |-> (kind_q == K_LOAD || kind_q == K_STORE));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_kind) && $stable(out_indirect));

  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready) && req_ready);

  p_trap_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == K_TRAP |-> out_addr[W-1:VEC_W] == '0 && !out_indirect);

  p_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == K_NONE |-> out_addr == '0 && !out_indirect);
endmodule

// File: rtl/effective_addr_gen.sv
module effective_addr_gen
  import eag_pkg::*;
#(
  parameter int W          = 16,
  parameter int OPC_W      = 4,
  parameter int FIELD_W    = 9,
  parameter int BASE_OFF_W = 6,
  parameter int VEC_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [OPC_W-1:0]   req_opcode,
  input  logic [FIELD_W-1:0] req_field,
  input  logic [W-1:0]       req_pc,
  input  logic [W-1:0]       req_base,
  output logic               ind_rd_valid,
  output logic [W-1:0]       ind_rd_addr,
  input  logic               ind_rd_ready,
  input  logic [W-1:0]       ind_rd_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W-1:0]       out_addr,
  output logic [2:0]         out_kind,
  output logic               out_indirect,
  output logic               done
);
  dec_t         dec;
  logic [W-1:0] calc_addr;
  acc_kind_e    kind_e;

  eag_decode u_decode (
    .opcode(req_opcode),
    .dec   (dec)
  );

  eag_addr_calc #(
    .W(W), .FIELD_W(FIELD_W), .BASE_OFF_W(BASE_OFF_W), .VEC_W(VEC_W)
  ) u_calc (
    .field(req_field),
    .pc   (req_pc),
    .base (req_base),
    .src  (dec.src),
    .addr (calc_addr)
  );

  eag_seq #(.W(W), .VEC_W(VEC_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .dec         (dec),
    .calc_addr   (calc_addr),
    .ind_rd_valid(ind_rd_valid),
    .ind_rd_addr (ind_rd_addr),
    .ind_rd_ready(ind_rd_ready),
    .ind_rd_data (ind_rd_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_kind    (kind_e),
    .out_indirect(out_indirect),
    .done        (done)
  );

  assign out_kind = kind_e;
endmodule

// File: tb/tb_effective_addr_gen.sv
module tb_effective_addr_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [3:0]  req_opcode;
  logic [8:0]  req_field;
  logic [15:0] req_pc, req_base;
  logic        ind_rd_valid, ind_rd_ready;
  logic [15:0] ind_rd_addr, ind_rd_data;
  logic        out_valid, out_ready, out_indirect, done;
  logic [15:0] out_addr;
  logic [2:0]  out_kind;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  effective_addr_gen dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_field(req_field),
    .req_pc(req_pc), .req_base(req_base),
    .ind_rd_valid(ind_rd_valid), .ind_rd_addr(ind_rd_addr),
    .ind_rd_ready(ind_rd_ready), .ind_rd_data(ind_rd_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_kind(out_kind),
    .out_indirect(out_indirect), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected address before indirection, kind, indirect flag, requirement tag.
  task automatic model(input logic [3:0] op, input logic [8:0] f,
                       input logic [15:0] pc, input logic [15:0] base,
                       output logic [15:0] a, output logic [2:0] k,
                       output bit ind, output string tag);
    logic [15:0] rel9, rel6;
    rel9 = pc + {{7{f[8]}}, f};
    rel6 = base + {{10{f[5]}}, f[5:0]};
    ind = 1'b0;
    case (op)
      4'b0010: begin a = rel9; k = 3'd1; tag = "R1"; end
      4'b0011: begin a = rel9; k = 3'd2; tag = "R1"; end
      4'b0110: begin a = rel6; k = 3'd1; tag = "R2"; end
      4'b0111: begin a = rel6; k = 3'd2; tag = "R2"; end
      4'b1010: begin a = rel9; k = 3'd1; ind = 1'b1; tag = "R3"; end
      4'b1011: begin a = rel9; k = 3'd2; ind = 1'b1; tag = "R3"; end
      4'b1110: begin a = rel9; k = 3'd3; tag = "R4"; end
      4'b1111: begin a = {8'h00, f[7:0]}; k = 3'd4; tag = "R5"; end
      default: begin a = 16'h0000; k = 3'd0; tag = "R6"; end
    endcase
  endtask

  // Called just after a falling edge with the block idle.
  task automatic run_txn(input logic [3:0] op, input logic [8:0] f,
                         input logic [15:0] pc, input logic [15:0] base,
                         input int lat, input int stall, input bit noise);
    logic [15:0] a, fin, word;
    logic [2:0]  k;
    bit          ind;
    string       tag;
    model(op, f, pc, base, a, k, ind, tag);
    word = a * 16'h9E37 + 16'h1234;
    fin  = ind ? word : a;

    req_valid = 1'b1; req_opcode = op; req_field = f; req_pc = pc; req_base = base;
    chk(req_ready == 1'b1, "R7", "ready when idle", {15'd0, req_ready}, 16'd1);
    @(negedge clk);
    // Busy-time noise: a different request must be ignored (R7).
    req_valid  = noise;
    req_opcode = ~op; req_field = ~f; req_pc = ~pc; req_base = ~base;

    if (ind) begin
      chk(ind_rd_valid == 1'b1, "R7", "pointer read after accept", {15'd0, ind_rd_valid}, 16'd1);
      chk(ind_rd_addr == a, "R3", "pointer read address", ind_rd_addr, a);
      chk(out_valid == 1'b0, "R8", "no result before read", {15'd0, out_valid}, 16'd0);
      for (int i = 0; i < lat; i++) begin
        chk(req_ready == 1'b0, "R7", "busy while reading", {15'd0, req_ready}, 16'd0);
        @(negedge clk);
        chk(ind_rd_valid == 1'b1 && ind_rd_addr == a, "R8", "read held", ind_rd_addr, a);
      end
      ind_rd_ready = 1'b1; ind_rd_data = word;
      @(negedge clk);
      ind_rd_ready = 1'b0; ind_rd_data = ~word;
      chk(out_valid == 1'b1, "R8", "result after read", {15'd0, out_valid}, 16'd1);
    end else begin
      chk(ind_rd_valid == 1'b0, (k == 3'd3) ? "R4" : "R6", "no pointer read",
          {15'd0, ind_rd_valid}, 16'd0);
      chk(out_valid == 1'b1, "R7", "result after accept", {15'd0, out_valid}, 16'd1);
    end

    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && out_addr == fin && out_kind == k && req_ready == 1'b0,
          "R9", "hold under back-pressure", out_addr, fin);
    end

    chk(out_addr == fin, tag, "address", out_addr, fin);
    chk(out_kind == k, "R6", "kind", {13'd0, out_kind}, {13'd0, k});
    chk(out_indirect == ind, "R3", "indirect flag", {15'd0, out_indirect}, {15'd0, ind});

    req_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(done == 1'b1, "R9", "done pulse", {15'd0, done}, 16'd1);
    chk(out_valid == 1'b0 && req_ready == 1'b1, "R9", "idle after take",
        {14'd0, out_valid, req_ready}, 16'd1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_opcode = '0; req_field = '0;
    req_pc = '0; req_base = '0; ind_rd_ready = 1'b0; ind_rd_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && out_valid == 1'b0 && ind_rd_valid == 1'b0 && done == 1'b0,
        "R10", "reset state", {12'd0, req_ready, out_valid, ind_rd_valid, done}, 16'h0008);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && out_valid == 1'b0, "R10", "idle after reset",
        {14'd0, done, out_valid}, 16'd0);

    // Wrap corner cases first.
    run_txn(4'b0010, 9'h0FF, 16'hFFFF, 16'h0000, 0, 0, 1'b0);   // R1 wraps upward
    run_txn(4'b0011, 9'h100, 16'h0010, 16'h0000, 0, 1, 1'b0);   // R1 wraps downward
    run_txn(4'b0110, 9'h020, 16'h0000, 16'h0005, 0, 0, 1'b0);   // R2 -32
    run_txn(4'b0111, 9'h11F, 16'h0000, 16'hFFF0, 0, 0, 1'b0);   // R2 +31, bit 8 ignored
    run_txn(4'b1010, 9'h1FF, 16'h0000, 16'h0000, 3, 2, 1'b1);   // R3 -1 wraps
    run_txn(4'b1111, 9'h1AB, 16'h3000, 16'h4000, 0, 0, 1'b0);   // R5 bit 8 not in vector

    // Sweep: every opcode against every 9-bit field value.
    for (int op = 0; op < 16; op++) begin
      for (int f = 0; f < 512; f++) begin
        int          idx;
        logic [15:0] pc, base;
        idx  = op * 512 + f;
        pc   = (idx % 8 == 0) ? 16'hFFFF : 16'(idx * 16'h2F1B);
        base = (idx % 8 == 1) ? 16'hFFF0 : ~16'(idx * 16'h01D3);
        run_txn(4'(op), 9'(f), pc, base, idx % 4, (idx / 4) % 3, (idx % 5) == 0);
      end
    end
    finish_run();
  end
endmodule